// File: doc/BRIEF.md
# Instruction Target Address Unit

This unit sits between instruction fetch and execute in a processor with 24-bit words and 20-bit byte addresses. On a start pulse it takes the leading instruction bytes and a short kind code from the opcode decoder. From these it settles the instruction length and resolves the effective target address from the addressing flags and the base, index and program-counter registers. It then delivers the operand.

For memory-reference instructions the operand is obtained in one of three ways. It can be the address itself (immediate). It can be one word read at the address (simple). It can be a word read through a pointer word (indirect). All reads go through a byte-wide request/valid port. Register-only and single-byte instructions finish without touching memory.

A one-cycle done strobe marks the result. The strobe comes one cycle after the start pulse when no read is needed, and otherwise one cycle after the last byte is accepted. Out-of-range flag combinations are reported on an illegal flag.

Top module: `insn_target_unit`

## Requirements
- R1: After reset, done, mem_req, illegal, fmt_len, target_addr and operand are all zero.
- R2: op_kind 2'b01 or 2'b11 gives fmt_len 1 and operand = insn[31:24]. op_kind 2'b10 gives fmt_len 2 and operand = insn[31:16]. For both, target_addr is 0 and done rises the cycle after start. op_kind 2'b00 (memory reference) gives fmt_len 4 when insn[20] (long flag) is 1 and fmt_len 3 when it is 0, except in legacy mode (R6), which always has fmt_len 3.
- R3: With the base flag insn[22]=1 and the relative flag insn[21]=0, in short form, the target is base_reg plus insn[19:8] taken as unsigned.
- R4: With insn[22]=0 and insn[21]=1, in short form, the target is pc_reg plus insn[19:8] taken as signed. pc_reg is used as supplied, which is the address of the following instruction.
- R5: The index flag insn[23]=1 adds index_reg to the target. In long form with insn[22]=insn[21]=0, the target is insn[19:0].
- R6: When the mode flags insn[25] and insn[24] are both 0, the target is insn[22:8] (15 bits), plus index_reg when insn[23]=1. A simple word read follows.
- R7: insn[25]=0, insn[24]=1 (immediate) puts the target on operand, zero-extended. No read is made, and done rises the cycle after start.
- R8: Simple mode (insn[25]=insn[24]) reads bytes at target, target+1 and target+2. The lowest address supplies the most significant operand byte.
- R9: insn[25]=1, insn[24]=0 (indirect) first reads the word at target. Its low 20 bits become the address of a second three-byte read, which gives the operand. target_addr still reports the first address.
- R10: Base and relative flags both set, either flag set in long form, or index with immediate, raises illegal. In that case target_addr and operand are 0, no read is made, and done rises the cycle after start.
- R11: mem_addr holds while mem_req is high and mem_vld low. One byte is taken on each clock edge with mem_req and mem_vld both high. done is high exactly one cycle after the last byte is taken, and mem_req is then low.
- R12: A start pulse while an operation is in progress is ignored.
- R13: All target and byte-address arithmetic wraps modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_kind | input | 2 | Instruction kind from the opcode decoder |
| insn | input | 32 | Instruction bytes, first byte in [31:24] |
| base_reg | input | 20 | Base register value |
| index_reg | input | 20 | Index register value |
| pc_reg | input | 20 | Address of the following instruction |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 20 | Byte read address |
| mem_vld | input | 1 | Read byte valid |
| mem_data | input | 8 | Read byte |
| done | output | 1 | One-cycle result strobe |
| fmt_len | output | 3 | Instruction length in bytes |
| target_addr | output | 20 | Resolved target address |
| operand | output | 24 | Operand value |
| illegal | output | 1 | Illegal flag combination |

## Verification
The bench builds the unit with its default 20-bit address and 24-bit word. At these widths a program counter near the top of the space, and a long-form address of all ones, carry both the address adder and the byte stepping across the wrap point. A 24-bit word therefore means exactly three byte beats per read. The memory answers with latencies that rotate between zero and two idle cycles, so address holding and back-to-back acceptance are both covered. One indirect run fires a second start mid-fetch to show that it is ignored.

// File: rtl/insn_ta_pkg.sv
`timescale 1ns/1ps
package insn_ta_pkg;
  localparam int INSN_W = 32;

  typedef enum logic [1:0] {
    KIND_MEM  = 2'b00,
    KIND_ONE  = 2'b01,
    KIND_REG  = 2'b10,
    KIND_ONE2 = 2'b11
  } op_kind_e;

  typedef enum logic [1:0] {
    ACC_NONE     = 2'b00,
    ACC_IMM      = 2'b01,
    ACC_SIMPLE   = 2'b10,
    ACC_INDIRECT = 2'b11
  } access_e;

  typedef enum logic [1:0] {
    BASE_ZERO = 2'b00,
    BASE_B    = 2'b01,
    BASE_PC   = 2'b10
  } base_e;

  typedef struct packed {
    logic [2:0]  len;
    access_e     acc;
    base_e       base;
    logic        use_x;
    logic        illegal;
    logic [15:0] short_val;
  } decoded_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PTR  = 2'b01,
    ST_OPND = 2'b10
  } state_e;
endpackage

// File: rtl/insn_ta_decode.sv
`timescale 1ns/1ps
module insn_ta_decode
  import insn_ta_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [INSN_W-1:0] insn,
  input  op_kind_e          kind,
  output decoded_t          dec,
  output logic [ADDR_W-1:0] offset
);
  logic f_n, f_i, f_x, f_b, f_p, f_e;
  logic bad;

  assign f_n = insn[25];
  assign f_i = insn[24];
  assign f_x = insn[23];
  assign f_b = insn[22];
  assign f_p = insn[21];
  assign f_e = insn[20];

  assign bad = (f_b && f_p) || (f_e && (f_b || f_p)) || (f_x && f_i && !f_n);

  always_comb begin
    dec    = '0;
    offset = '0;
    unique case (kind)
      KIND_REG: begin
        dec.len       = 3'd2;
        dec.short_val = insn[31:16];
      end
      KIND_MEM: begin
        if (!f_n && !f_i) begin
          // legacy form: 15-bit address, only the index flag survives
          dec.len   = 3'd3;
          dec.acc   = ACC_SIMPLE;
          dec.use_x = f_x;
          offset    = ADDR_W'(insn[22:8]);
        end else begin
          dec.len     = f_e ? 3'd4 : 3'd3;
          dec.illegal = bad;
          if (!bad) begin
            dec.use_x = f_x;
            if (f_b)      dec.base = BASE_B;
            else if (f_p) dec.base = BASE_PC;
            if (f_e)      offset = ADDR_W'(insn[19:0]);
            else if (f_p) offset = ADDR_W'($signed(insn[19:8]));
            else          offset = ADDR_W'(insn[19:8]);
            if (f_i && !f_n)      dec.acc = ACC_IMM;
            else if (f_n && !f_i) dec.acc = ACC_INDIRECT;
            else                  dec.acc = ACC_SIMPLE;
          end
        end
      end
      default: begin
        dec.len       = 3'd1;
        dec.short_val = {8'h00, insn[31:24]};
      end
    endcase
  end
endmodule

// File: rtl/insn_ta_addr_gen.sv
`timescale 1ns/1ps
module insn_ta_addr_gen
  import insn_ta_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  access_e           acc,
  input  base_e             base,
  input  logic              use_x,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] base_reg,
  input  logic [ADDR_W-1:0] index_reg,
  input  logic [ADDR_W-1:0] pc_reg,
  output logic [ADDR_W-1:0] ta
);
  logic [ADDR_W-1:0] base_sel;
  logic [ADDR_W-1:0] idx_sel;

  always_comb begin
    unique case (base)
      BASE_B:  base_sel = base_reg;
      BASE_PC: base_sel = pc_reg;
      default: base_sel = '0;
    endcase
    idx_sel = use_x ? index_reg : '0;
    if (acc == ACC_NONE) ta = '0;
    else                 ta = base_sel + offset + idx_sel;
  end
endmodule

// File: rtl/insn_ta_word_fetch.sv
`timescale 1ns/1ps
module insn_ta_word_fetch #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_vld,
  input  logic [7:0]        mem_data,
  output logic              beat_last,
  output logic [WORD_W-1:0] word_next
);
  localparam int NBYTES = WORD_W / 8;
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int ACC_W  = WORD_W - 8;

  logic              active_q, active_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic              beat;

  assign beat      = active_q && mem_vld;
  assign beat_last = beat && (cnt_q == CNT_W'(NBYTES - 1));
  assign word_next = {acc_q, mem_data};
  assign mem_req   = active_q;
  assign mem_addr  = addr_q;

  always_comb begin
    active_d = active_q;
    addr_d   = addr_q;
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    if (beat) begin
      addr_d = addr_q + 1'b1;
      cnt_d  = cnt_q + 1'b1;
      acc_d  = word_next[ACC_W-1:0];
      if (beat_last) active_d = 1'b0;
    end
    if (load) begin
      active_d = 1'b1;
      addr_d   = load_addr;
      cnt_d    = '0;
      acc_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      cnt_q    <= '0;
      acc_q    <= '0;
    end else begin
      active_q <= active_d;
      addr_q   <= addr_d;
      cnt_q    <= cnt_d;
      acc_q    <= acc_d;
    end
  end

  assert_hold_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_vld) |=> (mem_req && $stable(mem_addr)));

  assert_next_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_vld && !beat_last) |=> (mem_req && mem_addr == $past(mem_addr) + 1'b1));
endmodule

// File: rtl/insn_target_unit.sv
`timescale 1ns/1ps
module insn_target_unit
  import insn_ta_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op_kind,
  input  logic [INSN_W-1:0] insn,
  input  logic [ADDR_W-1:0] base_reg,
  input  logic [ADDR_W-1:0] index_reg,
  input  logic [ADDR_W-1:0] pc_reg,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_vld,
  input  logic [7:0]        mem_data,
  output logic              done,
  output logic [2:0]        fmt_len,
  output logic [ADDR_W-1:0] target_addr,
  output logic [WORD_W-1:0] operand,
  output logic              illegal
);
  decoded_t          dec;
  logic [ADDR_W-1:0] off_now, ta_now;
  logic              fetch_load;
  logic [ADDR_W-1:0] fetch_addr;
  logic              beat_last;
  logic [WORD_W-1:0] word_next;

  insn_ta_decode #(.ADDR_W(ADDR_W)) u_decode (
    .insn   (insn),
    .kind   (op_kind_e'(op_kind)),
    .dec    (dec),
    .offset (off_now)
  );

  insn_ta_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .acc       (dec.acc),
    .base      (dec.base),
    .use_x     (dec.use_x),
    .offset    (off_now),
    .base_reg  (base_reg),
    .index_reg (index_reg),
    .pc_reg    (pc_reg),
    .ta        (ta_now)
  );

  insn_ta_word_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fetch_load),
    .load_addr (fetch_addr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_vld   (mem_vld),
    .mem_data  (mem_data),
    .beat_last (beat_last),
    .word_next (word_next)
  );

  state_e            st_q, st_d;
  logic              accept;
  logic [2:0]        hold_len_q;
  logic [ADDR_W-1:0] hold_ta_q;
  logic              out_en, done_d, ill_d;
  logic [2:0]        len_d;
  logic [ADDR_W-1:0] ta_d;
  logic [WORD_W-1:0] opnd_d;

  assign accept = start && (st_q == ST_IDLE);

  always_comb begin
    st_d       = st_q;
    fetch_load = 1'b0;
    fetch_addr = ta_now;
    out_en     = 1'b0;
    done_d     = 1'b0;
    len_d      = hold_len_q;
    ta_d       = hold_ta_q;
    opnd_d     = word_next;
    ill_d      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          unique case (dec.acc)
            ACC_SIMPLE: begin
              fetch_load = 1'b1;
              st_d       = ST_OPND;
            end
            ACC_INDIRECT: begin
              fetch_load = 1'b1;
              st_d       = ST_PTR;
            end
            default: begin
              out_en = 1'b1;
              done_d = 1'b1;
              len_d  = dec.len;
              ta_d   = ta_now;
              ill_d  = dec.illegal;
              opnd_d = (dec.acc == ACC_IMM) ? WORD_W'(ta_now) : WORD_W'(dec.short_val);
            end
          endcase
        end
      end
      ST_PTR: begin
        if (beat_last) begin
          fetch_load = 1'b1;
          fetch_addr = word_next[ADDR_W-1:0];
          st_d       = ST_OPND;
        end
      end
      ST_OPND: begin
        if (beat_last) begin
          out_en = 1'b1;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      hold_len_q  <= '0;
      hold_ta_q   <= '0;
      done        <= 1'b0;
      fmt_len     <= '0;
      target_addr <= '0;
      operand     <= '0;
      illegal     <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
      if (accept) begin
        hold_len_q <= dec.len;
        hold_ta_q  <= ta_now;
      end
      if (out_en) begin
        fmt_len     <= len_d;
        target_addr <= ta_d;
        operand     <= opnd_d;
        illegal     <= ill_d;
      end
    end
  end

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> ($stable(hold_ta_q) && $stable(hold_len_q)));

  assert_len_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fmt_len != 3'd0 && fmt_len <= 3'd4));

  assert_illegal_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (operand == '0 && target_addr == '0));

  assert_ptr_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PTR && beat_last) |=> (mem_req && mem_addr == $past(word_next[ADDR_W-1:0])));
endmodule

// File: tb/insn_target_unit_tb.sv
`timescale 1ns/1ps
module insn_target_unit_tb;
  localparam int unsigned AMASK = 32'h000F_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op_kind;
  logic [31:0] insn;
  logic [19:0] base_reg, index_reg, pc_reg;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_vld;
  logic [7:0]  mem_data;
  logic        done;
  logic [2:0]  fmt_len;
  logic [19:0] target_addr;
  logic [23:0] operand;
  logic        illegal;

  int n_cmp = 0;
  int n_bad = 0;
  int lat_seed = 0;
  bit all_done = 0;

  int unsigned e_len, e_ta, e_op;
  bit          e_ill;
  int unsigned e_addr[$];

  always #2.5 clk = ~clk;

  insn_target_unit u_dut (
    .clk, .rst_n, .start, .op_kind, .insn, .base_reg, .index_reg, .pc_reg,
    .mem_req, .mem_addr, .mem_vld, .mem_data,
    .done, .fmt_len, .target_addr, .operand, .illegal
  );

  function automatic logic [7:0] mem_byte(input int unsigned a);
    return 8'((a * 7) ^ (a >> 5) ^ 32'h5A);
  endfunction

  function automatic logic [31:0] mk3(input logic [5:0] op, input logic n, input logic i,
      input logic x, input logic b, input logic p, input logic [11:0] d);
    return {op, n, i, x, b, p, 1'b0, d, 8'h00};
  endfunction

  function automatic logic [31:0] mk4(input logic [5:0] op, input logic n, input logic i,
      input logic x, input logic b, input logic p, input logic [19:0] a);
    return {op, n, i, x, b, p, 1'b1, a};
  endfunction

  function automatic logic [31:0] mkl(input logic [5:0] op, input logic x, input logic [14:0] a);
    return {op, 2'b00, x, a, 8'h00};
  endfunction

  task automatic chk(input string req, input string what, input int unsigned got, input int unsigned exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // behavioural read of one word, pushing the expected byte addresses
  function automatic int unsigned read_word(input int unsigned a);
    int unsigned w = 0;
    for (int k = 0; k < 3; k++) begin
      int unsigned ba = (a + k) & AMASK;
      e_addr.push_back(ba);
      w = (w << 8) | mem_byte(ba);
    end
    return w;
  endfunction

  task automatic model(input logic [31:0] ins, input logic [1:0] kind,
      input int unsigned bb, input int unsigned xx, input int unsigned pc);
    bit n, i, x, b, p, e;
    int unsigned disp, ta, ptr;
    e_len = 0; e_ta = 0; e_op = 0; e_ill = 0;
    e_addr.delete();
    if (kind == 2'b01 || kind == 2'b11) begin e_len = 1; e_op = ins[31:24]; return; end
    if (kind == 2'b10) begin e_len = 2; e_op = ins[31:16]; return; end
    n = ins[25]; i = ins[24]; x = ins[23]; b = ins[22]; p = ins[21]; e = ins[20];
    if (!n && !i) begin
      e_len = 3;
      ta = (ins[22:8] + (x ? xx : 0)) & AMASK;
      e_ta = ta;
      e_op = read_word(ta);
      return;
    end
    e_len = e ? 4 : 3;
    if ((b && p) || (e && (b || p)) || (x && i && !n)) begin e_ill = 1; return; end
    if (e)      disp = ins[19:0];
    else if (p) disp = ins[19] ? (32'(ins[19:8]) | 32'hFFFF_F000) : 32'(ins[19:8]);
    else        disp = ins[19:8];
    ta = (disp + (b ? bb : 0) + (p ? pc : 0) + (x ? xx : 0)) & AMASK;
    e_ta = ta;
    if (i && !n) begin e_op = ta; return; end
    if (n && !i) begin
      ptr = read_word(ta) & AMASK;
      e_op = read_word(ptr);
      return;
    end
    e_op = read_word(ta);
  endtask

  task automatic run_op(input string tag, input logic [31:0] ins, input logic [1:0] kind,
      input int unsigned bb, input int unsigned xx, input int unsigned pc, input bit ghost);
    int idx = 0;
    int it = 0;
    int lat;
    bit pend;
    bit fin = 0;
    model(ins, kind, bb, xx, pc);
    @(negedge clk);
    insn = ins; op_kind = kind;
    base_reg = 20'(bb); index_reg = 20'(xx); pc_reg = 20'(pc);
    start = 1'b1;
    pend = (e_addr.size() == 0);
    lat = lat_seed % 3;
    while (!fin) begin
      bit now_pend = 0;
      @(negedge clk);
      start = (ghost && it == 1);
      if (start) insn = ~ins;
      chk("R11", "done timing", done, pend);
      if (done) begin
        chk(tag, "fmt_len", fmt_len, e_len);
        chk(tag, "target_addr", target_addr, e_ta);
        chk(tag, "operand", operand, e_op);
        chk(tag, "illegal", illegal, e_ill);
        fin = 1;
      end
      mem_vld = 1'b0;
      if (mem_req) begin
        if (idx >= e_addr.size()) begin
          chk("R11", "unexpected read", 1, 0);
        end else if (lat == 0) begin
          chk("R11", "read address", mem_addr, e_addr[idx]);
          mem_vld  = 1'b1;
          mem_data = mem_byte(mem_addr);
          idx++;
          if (idx == e_addr.size()) now_pend = 1;
          lat_seed++;
          lat = lat_seed % 3;
        end else begin
          lat--;
        end
      end
      pend = now_pend;
      it++;
      if (it > 60 && !fin) begin
        chk(tag, "operation timeout", 1, 0);
        fin = 1;
      end
    end
    @(negedge clk);
    mem_vld = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!all_done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_kind = 2'b00; insn = '0;
    base_reg = '0; index_reg = '0; pc_reg = '0; mem_vld = 1'b0; mem_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", done, 0);
    chk("R1", "mem_req", mem_req, 0);
    chk("R1", "fmt_len", fmt_len, 0);
    chk("R1", "target_addr", target_addr, 0);
    chk("R1", "operand", operand, 0);
    chk("R1", "illegal", illegal, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 short kinds
    run_op("R2", 32'hC4AB_CDEF, 2'b01, 32'h1200, 32'h30, 32'h3003, 0);
    run_op("R2", 32'h9053_1122, 2'b10, 32'h1200, 32'h30, 32'h3003, 0);
    run_op("R2", 32'hF800_0000, 2'b11, 32'h1200, 32'h30, 32'h3003, 0);
    // R7 immediate, direct and pc-relative negative
    run_op("R7", mk3(6'h00, 0, 1, 0, 0, 0, 12'h05A), 2'b00, 32'h1200, 32'h30, 32'h3003, 0);
    run_op("R4 R7", mk3(6'h01, 0, 1, 0, 0, 1, 12'hFF0), 2'b00, 32'h1200, 32'h30, 32'h3003, 0);
    // R3 base relative, top of unsigned range, simple read
    run_op("R3 R8", mk3(6'h05, 1, 1, 0, 1, 0, 12'hFFF), 2'b00, 32'h1200, 32'h30, 32'h3003, 0);
    // R4 R5 pc relative, positive, indexed
    run_op("R4 R5", mk3(6'h06, 1, 1, 1, 0, 1, 12'h7FF), 2'b00, 32'h1200, 32'h30, 32'h3003, 0);
    // R9 indirect with base, start pulsed mid-fetch (R12)
    run_op("R9 R12", mk3(6'h0A, 1, 0, 0, 1, 0, 12'h010), 2'b00, 32'h1200, 32'h30, 32'h3003, 1);
    // R5 R13 long form indexed, wrapping
    run_op("R5 R13", mk4(6'h0C, 1, 1, 1, 0, 0, 20'hFFFFE), 2'b00, 32'h1200, 32'h30, 32'h3003, 0);
    run_op("R2 R7", mk4(6'h0C, 0, 1, 0, 0, 0, 20'h12345), 2'b00, 32'h1200, 32'h30, 32'h3003, 0);
    // R6 legacy, indexed and with the long-flag bit inside the address
    run_op("R6", mkl(6'h02, 1, 15'h7FF0), 2'b00, 32'h1200, 32'h30, 32'h3003, 0);
    run_op("R6", mkl(6'h03, 0, 15'h5234), 2'b00, 32'h1200, 32'h30, 32'h3003, 0);
    // R10 illegal combinations
    run_op("R10", mk3(6'h04, 1, 1, 0, 1, 1, 12'h100), 2'b00, 32'h1200, 32'h30, 32'h3003, 0);
    run_op("R10", mk4(6'h04, 1, 1, 0, 0, 1, 20'h00100), 2'b00, 32'h1200, 32'h30, 32'h3003, 0);
    run_op("R10", mk3(6'h04, 0, 1, 1, 0, 0, 12'h100), 2'b00, 32'h1200, 32'h30, 32'h3003, 0);
    // R13 pc near top of space
    run_op("R13 R4", mk3(6'h07, 0, 1, 0, 0, 1, 12'h7F0), 2'b00, 32'h1200, 32'h30, 32'hFFFF0, 0);
    // R9 R13 long indirect through the wrap point, with a ghost start
    run_op("R9 R13 R12", mk4(6'h08, 1, 0, 0, 0, 0, 20'hFFFFF), 2'b00, 32'h1200, 32'h30, 32'h3003, 1);
    // R8 plain simple read
    run_op("R8", mk3(6'h09, 1, 1, 0, 0, 0, 12'h100), 2'b00, 32'h1200, 32'h30, 32'h3003, 0);

    all_done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule